// File: doc/BRIEF.md
# DMA Event and Interrupt Router

This block sits between the on-chip peripherals and a six-channel DMA engine. Each channel owns a 4-bit event-select field. The field either leaves the channel free-running, or ties it to one of eight peripheral events. Those events are the receive and transmit events of three serial ports, a "receive FIFO not empty" flag and a "transmit FIFO not full" flag. The block turns the rising edge of the chosen event into a one-cycle request for that channel. A 2-bit route field decides what drives four CPU interrupt lines. Each line is fed either by a serial-port receive/transmit interrupt or by a completion interrupt of DMA channel 0 to 3.

Both kinds of field sit behind a small register bus: an address, a write strobe and write data, with read data returned combinationally. The event and interrupt pins are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. A request that the DMA engine is not ready for is the engine's own concern.

Top module: `dma_evt_router`

## Requirements
- R1: After reset every select field reads 0, `free_run_o` is all ones, `sync_req_o` is 0 and the interrupt route is serial-only.
- R2: A write with `reg_addr` 0 to 5 stores `reg_wdata` in that channel's select field. Address 6 stores `reg_wdata[1:0]` as the route field and reads back with bits 3:2 as zero. Address 7 reads 0, and a write to it changes no field. Reads return the addressed field in the same cycle.
- R3: Select code 0 marks the channel unsynchronized. `free_run_o[c]` is high and the channel never raises `sync_req_o[c]`.
- R4: Select code k (1 to 8) picks `evt_i[k-1]`. The event bit order is: 0 serial port 0 receive, 1 serial port 0 transmit, 2 serial port 2 receive, 3 serial port 2 transmit, 4 serial port 1 receive, 5 serial port 1 transmit, 6 receive FIFO not empty, 7 transmit FIFO not full. A 0-to-1 change of the picked event, seen at a clock edge, raises `sync_req_o[c]` for exactly the cycle after that edge.
- R5: An event held high produces a single request, not one per cycle.
- R6: Reserved select codes 9 to 15 give no request, and `free_run_o[c]` is low.
- R7: Route 00: `irq_o` = `sp_irq_i`, whose bit order is serial port 2 receive, serial port 2 transmit, serial port 1 receive and serial port 1 transmit, from bit 0 to bit 3.
- R8: Route 01: `irq_o[1:0]` = `sp_irq_i[1:0]`, `irq_o[2]` = `dma_done_i[2]` and `irq_o[3]` = `dma_done_i[3]`.
- R9: Route 10: `irq_o` = `dma_done_i`, where bit n is the completion of DMA channel n.
- R10: Route 11 is reserved and drives all four interrupt lines low.
- R11: Channels act independently. Each reacts only to the event its own field selects, even when several events rise at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address: 0-5 channel select, 6 interrupt route |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data for `reg_addr` |
| evt_i | input | 8 | Peripheral event levels, ordered as in R4 |
| sp_irq_i | input | 4 | Serial-port interrupts, ordered as in R7 |
| dma_done_i | input | 4 | DMA channel 0-3 completion interrupts |
| sync_req_o | output | 6 | Per-channel synchronization request pulse |
| free_run_o | output | 6 | Per-channel unsynchronized flag |
| irq_o | output | 4 | Shared CPU interrupt lines |

## Verification
The event path is swept by giving the six channels staggered codes, so that over 16 rounds every channel takes all 16 codes. Each round raises each of the eight events alone, which separates a correct decode from an off-by-one or swapped event index. Each round also raises all eight events at once, which shows whether channels keep to their own selection. The held-high cycle after each edge separates edge detection from level passing. The interrupt router is tried with all 256 combinations of serial and completion inputs under each of the four routes, so that any crossed, stuck or leaking line shows up.

// File: rtl/dma_router_pkg.sv
package dma_router_pkg;
  typedef enum logic [1:0] {
    ROUTE_SERIAL = 2'b00,
    ROUTE_MIXED  = 2'b01,
    ROUTE_DMA    = 2'b10,
    ROUTE_NONE   = 2'b11
  } route_e;
endpackage

// File: rtl/dma_router_regs.sv
module dma_router_regs #(
  parameter int NUM_CH = 6,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic                          reg_we,
  input  logic [SEL_W-1:0]              reg_wdata,
  output logic [SEL_W-1:0]              reg_rdata,
  output logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel_o,
  output dma_router_pkg::route_e        route_o
);
  import dma_router_pkg::*;

  localparam logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'(NUM_CH);

  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;
  route_e                       route_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_q[c] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(c))
        sel_q[c] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      route_q <= ROUTE_SERIAL;
    else if (reg_we && reg_addr == ROUTE_ADDR)
      route_q <= route_e'(reg_wdata[1:0]);
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (reg_addr == ADDR_W'(c)) reg_rdata = sel_q[c];
    if (reg_addr == ROUTE_ADDR) reg_rdata = SEL_W'(route_q);
  end

  assign ch_sel_o = sel_q;
  assign route_o  = route_q;

  AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ROUTE_ADDR) |=> (route_q == $past(reg_wdata[1:0]))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we) |=> $stable(sel_q)); // R2
endmodule

// File: rtl/dma_evt_edge.sv
module dma_evt_edge #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] rise_o
);
  logic [NUM_EVT-1:0] evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_i;
  end

  assign rise_o = evt_i & ~evt_q;

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0)); // R5
endmodule

// File: rtl/dma_sync_select.sv
module dma_sync_select #(
  parameter int SEL_W   = 4,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] rise_i,
  output logic               req_o,
  output logic               free_o
);
  logic hit;
  logic req_q;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (sel_i == SEL_W'(k + 1)) hit = rise_i[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= hit;
  end

  assign req_o  = req_q;
  assign free_o = (sel_i == '0);

  AST_FREE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |=> !req_q); // R3
  AST_RESERVED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i > SEL_W'(NUM_EVT)) |=> !req_q); // R6
  AST_REQ_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(|rise_i)); // R4
endmodule

// File: rtl/dma_irq_mux.sv
module dma_irq_mux #(
  parameter int NUM_IRQ = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dma_router_pkg::route_e route_i,
  input  logic [NUM_IRQ-1:0]     sp_irq_i,
  input  logic [NUM_IRQ-1:0]     dma_done_i,
  output logic [NUM_IRQ-1:0]     irq_o
);
  import dma_router_pkg::*;

  localparam int HALF = NUM_IRQ / 2;

  always_comb begin
    unique case (route_i)
      ROUTE_SERIAL: irq_o = sp_irq_i;
      ROUTE_MIXED:  irq_o = {dma_done_i[NUM_IRQ-1:HALF], sp_irq_i[HALF-1:0]};
      ROUTE_DMA:    irq_o = dma_done_i;
      default:      irq_o = '0;
    endcase
  end

  AST_IRQ_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~(sp_irq_i | dma_done_i)) == '0)); // R7
  AST_IRQ_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (route_i == ROUTE_NONE) |-> (irq_o == '0)); // R10
  AST_IRQ_LOW_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (route_i != ROUTE_DMA) |-> (irq_o[HALF-1:0] == sp_irq_i[HALF-1:0]) || route_i == ROUTE_NONE); // R8
endmodule

// File: rtl/dma_evt_router.sv
module dma_evt_router #(
  parameter int NUM_CH  = 6,
  parameter int SEL_W   = 4,
  parameter int NUM_EVT = 8,
  parameter int NUM_IRQ = 4,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [SEL_W-1:0]   reg_wdata,
  output logic [SEL_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_IRQ-1:0] sp_irq_i,
  input  logic [NUM_IRQ-1:0] dma_done_i,
  output logic [NUM_CH-1:0]  sync_req_o,
  output logic [NUM_CH-1:0]  free_run_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  import dma_router_pkg::*;

  logic [NUM_CH-1:0][SEL_W-1:0] ch_sel;
  route_e                       route;
  logic [NUM_EVT-1:0]           rise;

  dma_router_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_sel_o(ch_sel), .route_o(route)
  );

  dma_evt_edge #(.NUM_EVT(NUM_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rise_o(rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
    dma_sync_select #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_sel (
      .clk(clk), .rst_n(rst_n), .sel_i(ch_sel[c]), .rise_i(rise),
      .req_o(sync_req_o[c]), .free_o(free_run_o[c])
    );
  end

  dma_irq_mux #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .route_i(route), .sp_irq_i(sp_irq_i),
    .dma_done_i(dma_done_i), .irq_o(irq_o)
  );

  AST_FREE_NOT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((free_run_o & sync_req_o & $past(free_run_o)) == '0)); // R11
endmodule

// File: tb/dma_evt_router_tb.sv
module dma_evt_router_tb;
  localparam int NCH = 6;
  localparam int NEVT = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_we;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic [7:0] evt_i;
  logic [3:0] sp_irq_i, dma_done_i;
  logic [5:0] sync_req_o, free_run_o;
  logic [3:0] irq_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [3:0] codes [NCH];

  always #2 clk = ~clk;

  dma_evt_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .sp_irq_i(sp_irq_i), .dma_done_i(dma_done_i), .sync_req_o(sync_req_o),
    .free_run_o(free_run_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [3:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  function automatic logic [5:0] exp_req(input logic [7:0] rising);
    logic [5:0] r = '0;
    for (int c = 0; c < NCH; c++)
      if (codes[c] >= 1 && codes[c] <= 8) r[c] = rising[codes[c]-1];
    return r;
  endfunction

  function automatic logic [5:0] exp_free();
    logic [5:0] r = '0;
    for (int c = 0; c < NCH; c++) r[c] = (codes[c] == 0);
    return r;
  endfunction

  task automatic pulse(input logic [7:0] pat, input string req);
    logic [5:0] e;
    e = exp_req(pat);
    evt_i = pat;
    @(negedge clk);
    chk(sync_req_o == e, req, sync_req_o, e);
    @(negedge clk);
    chk(sync_req_o == 6'h0, "R5", sync_req_o, 0);
    evt_i = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    evt_i = '0; sp_irq_i = 4'b1010; dma_done_i = 4'b0101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 4'h0, "R1");
    chk(free_run_o == 6'h3F, "R1", free_run_o, 6'h3F);
    chk(sync_req_o == 6'h0, "R1", sync_req_o, 0);
    chk(irq_o == sp_irq_i, "R1", irq_o, sp_irq_i);

    // R2 register write and readback
    for (int c = 0; c < NCH; c++) wr(3'(c), 4'(c + 9));
    wr(3'd6, 4'hF);
    for (int c = 0; c < NCH; c++) rd_chk(3'(c), 4'(c + 9), "R2");
    rd_chk(3'd6, 4'h3, "R2");
    wr(3'd7, 4'h5);
    for (int c = 0; c < NCH; c++) rd_chk(3'(c), 4'(c + 9), "R2");
    rd_chk(3'd6, 4'h3, "R2");
    rd_chk(3'd7, 4'h0, "R2");

    // R3 R4 R5 R6 R11: staggered code sweep
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < NCH; c++) begin
        codes[c] = 4'((r + c) % 16);
        wr(3'(c), codes[c]);
      end
      @(negedge clk);
      chk(free_run_o == exp_free(), "R3/R6", free_run_o, exp_free());
      for (int e = 0; e < NEVT; e++) pulse(8'(1 << e), "R4");
      pulse(8'hFF, "R11");
    end

    // R3 and R6 explicit: all channels code 0 then reserved
    for (int c = 0; c < NCH; c++) begin codes[c] = 4'h0; wr(3'(c), 4'h0); end
    pulse(8'hFF, "R3");
    for (int c = 0; c < NCH; c++) begin codes[c] = 4'(9 + c); wr(3'(c), codes[c]); end
    pulse(8'hFF, "R6");
    chk(free_run_o == 6'h0, "R6", free_run_o, 0);

    // R7..R10 interrupt routing sweep
    for (int s = 0; s < 4; s++) begin
      wr(3'd6, 4'(s));
      for (int p = 0; p < 256; p++) begin
        logic [3:0] ex;
        sp_irq_i = p[3:0];
        dma_done_i = p[7:4];
        #1;
        case (s)
          0: ex = p[3:0];
          1: ex = {p[7:6], p[1:0]};
          2: ex = p[7:4];
          default: ex = 4'h0;
        endcase
        case (s)
          0: chk(irq_o == ex, "R7", irq_o, ex);
          1: chk(irq_o == ex, "R8", irq_o, ex);
          2: chk(irq_o == ex, "R9", irq_o, ex);
          default: chk(irq_o == ex, "R10", irq_o, ex);
        endcase
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule